// File: doc/BRIEF.md
# Posit Compare and Sign Unit

This unit applies the posit operations that work directly on the raw encoding, with no field decoding. Because posit words sort exactly like two's-complement integers, the four ordering compares reduce to signed integer compares of the words. Equality and inequality are bitwise matches. Negation is the two's complement of the whole word. Absolute value negates negative words and passes the others through. Min and max pick one of the two operands unchanged.

A request is presented on `in_valid` with a 4-bit opcode and two operand words. One clock later the registered data result, the boolean flag and the exception output appear with `out_valid`. Zero has one encoding, all zeros. There is no range of NaN codes. The single not-a-real (NaR) word, a one followed by zeros, raises the exception output instead of acting as a quiet value.

A two-state controller tracks whether the output registers hold a fresh result. ST_IDLE means no result is pending, and ST_LIVE means a result was captured on the last edge. The transition into ST_LIVE is "accept", taken from either state when `in_valid` is high. The transition into ST_IDLE is "drain", taken from either state when `in_valid` is low.

Top module: `posit_cmp_unit`

## Requirements
- R1: One clock edge after `in_valid` is high, `out_valid` is high with that request's outputs. After an edge with `in_valid` low, `out_valid` is low. Reset clears `out_valid`, `result`, `flag` and `exc` to zero.
- R2: Opcodes 0 (LT), 1 (LE), 2 (GT) and 3 (GE) set `flag` to the signed two's-complement comparison of `opnd_a` against `opnd_b`.
- R3: Opcode 4 (EQ) sets `flag` when the two words are bit-identical. Opcode 5 (NE) sets `flag` when they differ.
- R4: Opcode 6 (NEG) returns the two's complement of `opnd_a`. Zero maps to zero, and NaR maps to itself.
- R5: Opcode 7 (ABS) returns the negation of `opnd_a` when its top bit is 1, and `opnd_a` otherwise. NaR maps to itself.
- R6: Opcode 8 (MIN) returns the signed-smaller operand unchanged, and opcode 9 (MAX) returns the signed-larger one. With equal operands, the common value is returned.
- R7: On any opcode from 0 to 9, a NaR operand raises `exc` for that result, and `flag` is forced low, including for NE. MIN and MAX with a NaR operand return the NaR word.
- R8: NEG and ABS consider only `opnd_a`. A NaR word on `opnd_b` does not raise `exc` for them.
- R9: Compare opcodes return `result` = 0. NEG, ABS, MIN and MAX return `flag` = 0. Opcodes 10 to 15 return zero on `result`, `flag` and `exc`.
- R10: While `in_valid` is low, `result`, `flag` and `exc` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Opcode, 0 to 9 defined |
| opnd_a | input | WIDTH | First operand posit word |
| opnd_b | input | WIDTH | Second operand posit word |
| out_valid | output | 1 | Result registers hold a fresh result |
| result | output | WIDTH | Data result |
| flag | output | 1 | Boolean compare outcome |
| exc | output | 1 | NaR exception |

## Verification
The hardest case to reach is NaR, which sits at the most negative integer code. A plain signed compare would call it smaller than everything, so the exception path must override an ordering result that looks correct. The stimulus pairs NaR with ordinary words under LT, NE, EQ and MAX, so that without the override the flag would read high or MAX would return the other operand. It also places NaR on the ignored second operand of NEG, so that over-eager exception logic would show on `exc`.

// File: rtl/posit_bitops_pkg.sv
package posit_bitops_pkg;

    typedef enum logic [3:0] {
        OP_LT  = 4'd0,
        OP_LE  = 4'd1,
        OP_GT  = 4'd2,
        OP_GE  = 4'd3,
        OP_EQ  = 4'd4,
        OP_NE  = 4'd5,
        OP_NEG = 4'd6,
        OP_ABS = 4'd7,
        OP_MIN = 4'd8,
        OP_MAX = 4'd9
    } pop_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_LIVE = 1'b1
    } vstate_e;

endpackage

// File: rtl/posit_nar_detect.sv
module posit_nar_detect #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] word,
    output logic             is_nar
);
    localparam logic [WIDTH-1:0] NAR_CODE = {1'b1, {(WIDTH-1){1'b0}}};

    assign is_nar = (word == NAR_CODE);
endmodule

// File: rtl/posit_order_unit.sv
module posit_order_unit #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] lhs,
    input  logic [WIDTH-1:0] rhs,
    output logic             less,
    output logic             same
);
    // Posit words order like two's-complement integers.
    assign less = $signed(lhs) < $signed(rhs);
    assign same = (lhs == rhs);
endmodule

// File: rtl/posit_sign_unit.sv
module posit_sign_unit #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] word,
    output logic [WIDTH-1:0] negated,
    output logic [WIDTH-1:0] magnitude
);
    assign negated   = ~word + {{(WIDTH-1){1'b0}}, 1'b1};
    assign magnitude = word[WIDTH-1] ? negated : word;
endmodule

// File: rtl/posit_cmp_unit.sv
module posit_cmp_unit
    import posit_bitops_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [3:0]       op,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic             out_valid,
    output logic [WIDTH-1:0] result,
    output logic             flag,
    output logic             exc
);
    localparam int               N_OPND   = 2;
    localparam logic [WIDTH-1:0] NAR_CODE = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] opnd [N_OPND];
    logic [N_OPND-1:0] nar;
    logic less, same;
    logic [WIDTH-1:0] neg_a, abs_a;

    assign opnd[0] = opnd_a;
    assign opnd[1] = opnd_b;

    genvar gi;
    generate
        for (gi = 0; gi < N_OPND; gi++) begin : g_nar
            posit_nar_detect #(.WIDTH(WIDTH)) u_nar (
                .word   (opnd[gi]),
                .is_nar (nar[gi])
            );
        end
    endgenerate

    posit_order_unit #(.WIDTH(WIDTH)) u_order (
        .lhs  (opnd_a),
        .rhs  (opnd_b),
        .less (less),
        .same (same)
    );

    posit_sign_unit #(.WIDTH(WIDTH)) u_sign (
        .word      (opnd_a),
        .negated   (neg_a),
        .magnitude (abs_a)
    );

    pop_e             op_e;
    logic             unary;
    logic             nar_hit;
    logic [WIDTH-1:0] res_d;
    logic             flag_d;
    logic             exc_d;

    assign op_e    = pop_e'(op);
    assign unary   = (op_e == OP_NEG) || (op_e == OP_ABS);
    assign nar_hit = unary ? nar[0] : (|nar);

    always_comb begin
        res_d  = '0;
        flag_d = 1'b0;
        exc_d  = 1'b0;
        case (op_e)
            OP_LT:  begin exc_d = nar_hit; flag_d = !nar_hit && less;           end
            OP_LE:  begin exc_d = nar_hit; flag_d = !nar_hit && (less || same); end
            OP_GT:  begin exc_d = nar_hit; flag_d = !nar_hit && !less && !same; end
            OP_GE:  begin exc_d = nar_hit; flag_d = !nar_hit && !less;          end
            OP_EQ:  begin exc_d = nar_hit; flag_d = !nar_hit && same;           end
            OP_NE:  begin exc_d = nar_hit; flag_d = !nar_hit && !same;          end
            OP_NEG: begin exc_d = nar_hit; res_d = neg_a;                       end
            OP_ABS: begin exc_d = nar_hit; res_d = abs_a;                       end
            OP_MIN: begin
                exc_d = nar_hit;
                res_d = nar_hit ? NAR_CODE : (less ? opnd_a : opnd_b);
            end
            OP_MAX: begin
                exc_d = nar_hit;
                res_d = nar_hit ? NAR_CODE : (less ? opnd_b : opnd_a);
            end
            default: begin
                res_d  = '0;
                flag_d = 1'b0;
                exc_d  = 1'b0;
            end
        endcase
    end

    // Controller: accept -> ST_LIVE, drain -> ST_IDLE
    vstate_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: state_nx = in_valid ? ST_LIVE : ST_IDLE;
            ST_LIVE: state_nx = in_valid ? ST_LIVE : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
            flag   <= 1'b0;
            exc    <= 1'b0;
        end else if (in_valid) begin
            result <= res_d;
            flag   <= flag_d;
            exc    <= exc_d;
        end
    end

    assign out_valid = (state == ST_LIVE);

    // R1: result appears one edge after the request
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_drain_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R4: negation sums with the operand to zero
    p_neg_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_NEG) |=> (WIDTH'(result + $past(opnd_a)) == '0));
    // R6: min/max pick one of the inputs
    p_pick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_MIN || op == OP_MAX))
        |=> (result == $past(opnd_a) || result == $past(opnd_b)));
    // R7: exception forces the flag low
    p_nar_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && exc) |-> !flag);
    // R10: outputs hold while idle
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(flag) && $stable(exc)));
endmodule

// File: tb/sim_posit_cmp_unit.sv
module sim_posit_cmp_unit;
    localparam int W = 8;
    localparam int NV = 23;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [3:0] op = '0;
    logic [W-1:0] opnd_a = '0, opnd_b = '0;
    logic out_valid, flag, exc;
    logic [W-1:0] result;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    posit_cmp_unit #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid),
        .result(result), .flag(flag), .exc(exc)
    );

    // {op, a, b, expected result, expected flag, expected exc}
    localparam logic [29:0] VEC [NV] = '{
        {4'd0, 8'h05, 8'hF0, 8'h00, 1'b0, 1'b0}, // R2 5 < -16 false
        {4'd0, 8'hF0, 8'h05, 8'h00, 1'b1, 1'b0}, // R2
        {4'd1, 8'h7F, 8'h7F, 8'h00, 1'b1, 1'b0}, // R2
        {4'd2, 8'h7F, 8'h81, 8'h00, 1'b1, 1'b0}, // R2
        {4'd3, 8'h81, 8'h7F, 8'h00, 1'b0, 1'b0}, // R2
        {4'd4, 8'h3C, 8'h3C, 8'h00, 1'b1, 1'b0}, // R3
        {4'd5, 8'h3C, 8'h3D, 8'h00, 1'b1, 1'b0}, // R3
        {4'd6, 8'h01, 8'h00, 8'hFF, 1'b0, 1'b0}, // R4
        {4'd6, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0}, // R4 zero
        {4'd6, 8'h80, 8'h00, 8'h80, 1'b0, 1'b1}, // R4 NaR
        {4'd7, 8'hC0, 8'h00, 8'h40, 1'b0, 1'b0}, // R5
        {4'd7, 8'h7F, 8'h00, 8'h7F, 1'b0, 1'b0}, // R5
        {4'd7, 8'h80, 8'h00, 8'h80, 1'b0, 1'b1}, // R5 NaR
        {4'd8, 8'h10, 8'hF8, 8'hF8, 1'b0, 1'b0}, // R6
        {4'd9, 8'h10, 8'hF8, 8'h10, 1'b0, 1'b0}, // R6
        {4'd8, 8'h22, 8'h22, 8'h22, 1'b0, 1'b0}, // R6 equal
        {4'd8, 8'h7F, 8'h81, 8'h81, 1'b0, 1'b0}, // R6
        {4'd0, 8'h80, 8'h01, 8'h00, 1'b0, 1'b1}, // R7
        {4'd5, 8'h80, 8'h01, 8'h00, 1'b0, 1'b1}, // R7
        {4'd4, 8'h80, 8'h80, 8'h00, 1'b0, 1'b1}, // R7
        {4'd9, 8'h05, 8'h80, 8'h80, 1'b0, 1'b1}, // R7
        {4'd6, 8'h05, 8'h80, 8'hFB, 1'b0, 1'b0}, // R8
        {4'd15, 8'h12, 8'h34, 8'h00, 1'b0, 1'b0} // R9
    };

    function automatic string tag_of(input logic [3:0] o, input int idx);
        if (idx == 21) return "R8";
        if (idx >= 17 && idx <= 20) return "R7";
        case (o)
            4'd0, 4'd1, 4'd2, 4'd3: return "R2";
            4'd4, 4'd5:             return "R3";
            4'd6:                   return "R4";
            4'd7:                   return "R5";
            4'd8, 4'd9:             return "R6";
            default:                return "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic [W-1:0] er,
                         input logic ef, input logic ee, input logic ev);
        n_run++;
        if (result !== er || flag !== ef || exc !== ee || out_valid !== ev) begin
            n_fail++;
            $display("FAIL %s: got res=%h flag=%b exc=%b vld=%b, expected res=%h flag=%b exc=%b vld=%b",
                     req, result, flag, exc, out_valid, er, ef, ee, ev);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", '0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: compare ops give zero data, sign ops give zero flag (in table)
        for (int i = 0; i < NV; i++) begin
            in_valid = 1'b1;
            {op, opnd_a, opnd_b} = VEC[i][29:10];
            @(negedge clk);
            check(tag_of(VEC[i][29:26], i), VEC[i][9:2], VEC[i][1], VEC[i][0], 1'b1);
        end
        // R1 and R10: drain leaves outputs held, out_valid low
        in_valid = 1'b1; op = 4'd7; opnd_a = 8'hF6; opnd_b = 8'h00;
        @(negedge clk);
        check("R5", 8'h0A, 1'b0, 1'b0, 1'b1);
        in_valid = 1'b0; op = 4'd6; opnd_a = 8'h80; opnd_b = 8'h80;
        @(negedge clk);
        check("R1", 8'h0A, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check("R10", 8'h0A, 1'b0, 1'b0, 1'b0);
        // R1: a request after idle is accepted again
        in_valid = 1'b1; op = 4'd2; opnd_a = 8'h01; opnd_b = 8'hFF;
        @(negedge clk);
        check("R1", 8'h00, 1'b1, 1'b0, 1'b1);
        in_valid = 1'b0;
        @(negedge clk);
        check("R10", 8'h00, 1'b1, 1'b0, 1'b0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule